// File: doc/BRIEF.md
# Road-Window Hit Filter with Shared-Bus Readout

The block is one channel of a track trigger. Before an event starts, the road table is loaded with inclusive centroid windows. Each window is stored as a lower bound and an upper bound, at a slot index. While an event is open, every centroid that arrives is compared against all loaded windows in one cycle. A centroid that falls inside a window is a hit. It is stored together with the index of the window it fell into. When several windows contain the centroid, the lowest index wins.

Once the event closes, the channel holds a block of words for a readout bus that several channels share. It raises a bus request and waits for a grant. While it writes, it holds the bus: first a header word, then the stored hits in arrival order, then a trailer word. It lets go of the bus in the cycle after the trailer. Each output word gets exactly one write strobe cycle. The strobe is never raised while the grant is low. If the grant is taken away mid-block, the readout pauses and later resumes at the same word.

Top module: `road_hit_filter`

## Requirements
- R1: After reset, `bus_req`, `bus_hold` and `out_wr` are low and no road slot is valid. An event read out before any load therefore reports zero hits.
- R2: A centroid `c` is a hit on slot `i` when slot `i` is valid and `lo <= c <= hi`, with both ends inclusive. A slot with `lo > hi` never matches.
- R3: When more than one valid slot contains the centroid, the hit carries the lowest such slot index.
- R4: A centroid is examined only while an event is open. The window opens in the cycle after `evt_start` and runs up to and including the cycle in which `evt_end` is high. A centroid given in the `evt_start` cycle or after the `evt_end` cycle is ignored. A centroid that matches no slot is not stored.
- R5: The block is written as follows:
  - The header is `{8'hE1, event[7:0], hit_count[15:0]}`.
  - Each hit word is `{slot_index[7:0], 8'h00, centroid[15:0]}`, with the fields zero-extended, and hits appear in arrival order.
  - The trailer is `{8'hFE, 22'b0, hit_drop, road_ovf}`.
- R6: After the event closes, `bus_req` rises. No word is written until `bus_gnt` has been seen high, and `out_wr` is never high while `bus_gnt` is low.
- R7: `bus_hold` is high on every write of the block. `bus_hold` and `bus_req` are both low in the cycle after the trailer write.
- R8: The hit store holds `HIT_DEPTH` hits. Further hits in the same event are dropped. The header count then equals `HIT_DEPTH` and trailer bit 1 is set.
- R9: A road load whose slot index is above `NROADS-1` changes no slot. It sets trailer bit 0, which stays set until `road_clr`.
- R10: A `road_clr` pulse invalidates every slot and clears the road-overflow flag.
- R11: The header event field starts at 0 after reset. It increases by one after each block and wraps from 255 to 0.
- R12: If `bus_gnt` drops while `bus_hold` is high, `out_data` holds its value and no word is skipped or repeated. Writing resumes once the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| road_we | input | 1 | Road slot write strobe |
| road_idx | input | IDXW | Slot index of the write |
| road_lo | input | CW | Window lower bound |
| road_hi | input | CW | Window upper bound |
| road_clr | input | 1 | Invalidate all slots, clear overflow flag |
| evt_start | input | 1 | Opens an event when the channel is idle |
| evt_end | input | 1 | Last cycle of the event window |
| cen_valid | input | 1 | Centroid present |
| cen_val | input | CW | Centroid value |
| bus_gnt | input | 1 | Bus grant from the shared arbiter |
| bus_req | output | 1 | Channel has a block pending or in flight |
| bus_hold | output | 1 | Channel owns the bus for the whole block |
| out_wr | output | 1 | One-cycle strobe per output word |
| out_data | output | 32 | Header, hit or trailer word |

## Verification
Two situations put two functions in the same cycle. In the first, the last centroid of an event is given in the `evt_end` cycle. It must be matched and counted even though the event closes on that edge. Extra centroids are given in the `evt_start` cycle and in the cycle after `evt_end`, and they must not appear in the block. In the second, the grant is toggled every cycle while the block is being written, so that pause and advance alternate. The bench then checks the received word list against an arithmetic model of the road table, which sweeps every centroid value of a small configuration. It also checks that no strobe ever came without a grant.

// File: rtl/road_hit_pkg.sv
package road_hit_pkg;

   localparam int          WORD_W  = 32;
   localparam logic [7:0]  HDR_TAG = 8'hE1;
   localparam logic [7:0]  TRL_TAG = 8'hFE;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_REQ,
      ST_HDR,
      ST_HIT,
      ST_TRL
   } rd_state_t;

endpackage

// File: rtl/road_table.sv
module road_table #(
   parameter int NROADS = 46,
   parameter int CW     = 12,
   parameter int IDXW   = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_we,
   input  logic [IDXW-1:0] ld_idx,
   input  logic [CW-1:0]   ld_lo,
   input  logic [CW-1:0]   ld_hi,
   input  logic            clr,
   input  logic [CW-1:0]   q_val,
   output logic            m_hit,
   output logic [IDXW-1:0] m_idx,
   output logic            ovf
);

   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NROADS - 1);

   logic [NROADS-1:0] vld_q;
   logic [NROADS-1:0] match;
   logic [CW-1:0]     lo_q [NROADS];
   logic [CW-1:0]     hi_q [NROADS];

   initial begin
      assert (NROADS >= 1 && NROADS <= 255);
      assert (IDXW == $clog2(NROADS + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int r = 0; r < NROADS; r++) begin
            lo_q[r] <= '0;
            hi_q[r] <= '0;
         end
      end else if (clr) begin
         vld_q <= '0;
      end else if (ld_we) begin
         for (int r = 0; r < NROADS; r++) begin
            if (ld_idx == IDXW'(r)) begin
               vld_q[r] <= 1'b1;
               lo_q[r]  <= ld_lo;
               hi_q[r]  <= ld_hi;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (clr)
         ovf <= 1'b0;
      else if (ld_we && (ld_idx > LAST_IDX))
         ovf <= 1'b1;
   end

   // one window comparator per slot
   for (genvar g = 0; g < NROADS; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (q_val >= lo_q[g]) && (q_val <= hi_q[g]);
   end

   // lowest slot index wins
   always_comb begin
      m_hit = 1'b0;
      m_idx = '0;
      for (int i = NROADS - 1; i >= 0; i--) begin
         if (match[i]) begin
            m_hit = 1'b1;
            m_idx = IDXW'(i);
         end
      end
   end

   AST_HIT_IN_ROAD: assert property (@(posedge clk) disable iff (!rst_n)
      m_hit |-> (vld_q[m_idx] && q_val >= lo_q[m_idx] && q_val <= hi_q[m_idx])); // R2

   AST_LOWEST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      m_hit |-> ($countones(match & ((NROADS'(1) << m_idx) - NROADS'(1))) == 0)); // R3

   AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(ld_we && !clr && (ld_idx > LAST_IDX))); // R9

endmodule

// File: rtl/hit_store.sv
module hit_store #(
   parameter int DEPTH = 32,
   parameter int EW    = 18,
   parameter int PW    = $clog2(DEPTH),
   parameter int CNTW  = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            wr,
   input  logic [EW-1:0]   wdata,
   input  logic [PW-1:0]   rd_ptr,
   output logic [EW-1:0]   rdata,
   output logic [CNTW-1:0] cnt,
   output logic            drop
);

   localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

   logic [EW-1:0] mem [DEPTH];

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 1024);
      assert (PW == $clog2(DEPTH) && CNTW == $clog2(DEPTH + 1));
   end

   always_ff @(posedge clk) begin
      if (wr && (cnt < FULL))
         mem[cnt[PW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         drop <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         drop <= 1'b0;
      end else if (wr) begin
         if (cnt < FULL)
            cnt <= cnt + CNTW'(1);
         else
            drop <= 1'b1;
      end
   end

   assign rdata = mem[rd_ptr];

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL); // R8

   AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drop) |-> ($past(cnt) == FULL)); // R8

endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
   import road_hit_pkg::*;
#(
   parameter int PW   = 5,
   parameter int CNTW = 6,
   parameter int EVW  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt_start,
   input  logic            evt_end,
   input  logic            bus_gnt,
   input  logic [CNTW-1:0] hit_cnt,
   output rd_state_t       state,
   output logic            collecting,
   output logic            store_clr,
   output logic [PW-1:0]   rd_ptr,
   output logic [EVW-1:0]  evt_num,
   output logic            bus_req,
   output logic            bus_hold,
   output logic            out_wr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rd_ptr  <= '0;
         evt_num <= '0;
      end else begin
         case (state)
            ST_IDLE:    if (evt_start) state <= ST_COLLECT;
            ST_COLLECT: if (evt_end)   state <= ST_REQ;
            ST_REQ:     if (bus_gnt)   state <= ST_HDR;
            ST_HDR: if (bus_gnt) begin
               rd_ptr <= '0;
               state  <= (hit_cnt == '0) ? ST_TRL : ST_HIT;
            end
            ST_HIT: if (bus_gnt) begin
               if (CNTW'(rd_ptr) + CNTW'(1) == hit_cnt)
                  state <= ST_TRL;
               else
                  rd_ptr <= rd_ptr + PW'(1);
            end
            ST_TRL: if (bus_gnt) begin
               state   <= ST_IDLE;
               evt_num <= evt_num + EVW'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign collecting = (state == ST_COLLECT);
   assign store_clr  = (state == ST_IDLE) && evt_start;
   assign bus_hold   = (state == ST_HDR) || (state == ST_HIT) || (state == ST_TRL);
   assign bus_req    = bus_hold || (state == ST_REQ);
   assign out_wr     = bus_hold && bus_gnt;

   AST_WR_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> bus_gnt); // R6

   AST_HOLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_hold) |-> $past(bus_req && bus_gnt)); // R6

   AST_REQ_DROPS_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_hold) |-> !bus_req); // R7

endmodule

// File: rtl/road_hit_filter.sv
module road_hit_filter
   import road_hit_pkg::*;
#(
   parameter int  NROADS    = 46,
   parameter int  CW        = 12,
   parameter int  HIT_DEPTH = 32,
   localparam int IDXW      = $clog2(NROADS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              road_we,
   input  logic [IDXW-1:0]   road_idx,
   input  logic [CW-1:0]     road_lo,
   input  logic [CW-1:0]     road_hi,
   input  logic              road_clr,
   input  logic              evt_start,
   input  logic              evt_end,
   input  logic              cen_valid,
   input  logic [CW-1:0]     cen_val,
   input  logic              bus_gnt,
   output logic              bus_req,
   output logic              bus_hold,
   output logic              out_wr,
   output logic [WORD_W-1:0] out_data
);

   localparam int PW   = $clog2(HIT_DEPTH);
   localparam int CNTW = $clog2(HIT_DEPTH + 1);
   localparam int EW   = IDXW + CW;
   localparam int EVW  = 8;

   initial begin
      assert (CW >= 1 && CW <= 16);
   end

   logic            m_hit;
   logic [IDXW-1:0] m_idx;
   logic            road_ovf;
   logic            collecting;
   logic            store_clr;
   logic [PW-1:0]   rd_ptr;
   logic [EW-1:0]   rd_entry;
   logic [CNTW-1:0] hit_cnt;
   logic            hit_drop;
   logic [EVW-1:0]  evt_num;
   rd_state_t       state;

   road_table #(.NROADS(NROADS), .CW(CW), .IDXW(IDXW)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_we  (road_we),
      .ld_idx (road_idx),
      .ld_lo  (road_lo),
      .ld_hi  (road_hi),
      .clr    (road_clr),
      .q_val  (cen_val),
      .m_hit  (m_hit),
      .m_idx  (m_idx),
      .ovf    (road_ovf)
   );

   hit_store #(.DEPTH(HIT_DEPTH), .EW(EW), .PW(PW), .CNTW(CNTW)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (store_clr),
      .wr     (collecting && cen_valid && m_hit),
      .wdata  ({m_idx, cen_val}),
      .rd_ptr (rd_ptr),
      .rdata  (rd_entry),
      .cnt    (hit_cnt),
      .drop   (hit_drop)
   );

   readout_ctrl #(.PW(PW), .CNTW(CNTW), .EVW(EVW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_start  (evt_start),
      .evt_end    (evt_end),
      .bus_gnt    (bus_gnt),
      .hit_cnt    (hit_cnt),
      .state      (state),
      .collecting (collecting),
      .store_clr  (store_clr),
      .rd_ptr     (rd_ptr),
      .evt_num    (evt_num),
      .bus_req    (bus_req),
      .bus_hold   (bus_hold),
      .out_wr     (out_wr)
   );

   logic [IDXW-1:0] ent_idx;
   logic [CW-1:0]   ent_cen;
   assign {ent_idx, ent_cen} = rd_entry;

   always_comb begin
      case (state)
         ST_HDR:  out_data = {HDR_TAG, evt_num, 16'(hit_cnt)};
         ST_HIT:  out_data = {8'(ent_idx), 8'h00, 16'(ent_cen)};
         ST_TRL:  out_data = {TRL_TAG, 22'b0, hit_drop, road_ovf};
         default: out_data = '0;
      endcase
   end

   AST_TRAILER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_hold) |-> $past(out_wr && out_data[31:24] == TRL_TAG)); // R7

   AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hold && !bus_gnt) |=> (!bus_hold || $stable(out_data))); // R12

endmodule

// File: tb/road_hit_filter_tb.sv
`timescale 1ns/1ps
module road_hit_filter_tb;

   localparam int NR   = 8;
   localparam int CWB  = 6;
   localparam int DEP  = 64;
   localparam int IW   = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic road_we = 0, road_clr = 0, evt_start = 0, evt_end = 0, cen_valid = 0;
   logic [IW-1:0]  road_idx = '0;
   logic [CWB-1:0] road_lo = '0, road_hi = '0, cen_val = '0;
   logic bus_gnt = 0;
   logic bus_req, bus_hold, out_wr;
   logic [31:0] out_data;

   road_hit_filter #(.NROADS(NR), .CW(CWB), .HIT_DEPTH(DEP)) u_dut (
      .clk(clk), .rst_n(rst_n), .road_we(road_we), .road_idx(road_idx),
      .road_lo(road_lo), .road_hi(road_hi), .road_clr(road_clr),
      .evt_start(evt_start), .evt_end(evt_end), .cen_valid(cen_valid),
      .cen_val(cen_val), .bus_gnt(bus_gnt), .bus_req(bus_req),
      .bus_hold(bus_hold), .out_wr(out_wr), .out_data(out_data));

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic gnt_allow = 1;
   bit   stall_mode = 0;

   // model of the shared arbiter: grant follows request, kept while held
   always @(posedge clk or negedge rst_n)
      if (!rst_n) bus_gnt <= 0;
      else        bus_gnt <= gnt_allow && (bus_req || bus_hold);

   always @(negedge clk) if (stall_mode) gnt_allow = ~gnt_allow;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // capture of the written block
   logic [31:0] cap [0:255];
   int  ncap = 0;
   bit  blk_done = 0;
   bit  chk_rel = 0;

   always @(negedge clk) begin
      if (chk_rel) begin
         check("R7 release after trailer", {30'b0, bus_hold, bus_req}, 32'h0);
         chk_rel = 0;
      end
      if (out_wr) begin
         if (!bus_gnt) check("R6 strobe without grant", 32'd1, 32'd0);
         if (!bus_hold) check("R7 hold during write", 32'd0, 32'd1);
         if (ncap < 256) cap[ncap] = out_data;
         ncap++;
         if (out_data[31:24] == 8'hFE) begin
            blk_done = 1;
            chk_rel  = 1;
         end
      end
   end

   // road table model
   int  m_lo [NR], m_hi [NR];
   bit  m_vld [NR];
   bit  m_rovf = 0;
   int  exp_evt = 0;
   int  ev_vals [0:127];

   task automatic load_road(input int idx, input int lo, input int hi);
      @(negedge clk);
      road_we = 1; road_idx = IW'(idx); road_lo = CWB'(lo); road_hi = CWB'(hi);
      @(negedge clk);
      road_we = 0;
      if (idx < NR) begin m_vld[idx] = 1; m_lo[idx] = lo; m_hi[idx] = hi; end
      else m_rovf = 1;
   endtask

   task automatic clear_roads();
      @(negedge clk); road_clr = 1;
      @(negedge clk); road_clr = 0;
      for (int i = 0; i < NR; i++) m_vld[i] = 0;
      m_rovf = 0;
   endtask

   task automatic drive_event(input int n, input bit overlap);
      ncap = 0; blk_done = 0;
      @(negedge clk);
      evt_start = 1; cen_valid = 1; cen_val = 6'd12;   // ignored, R4
      @(negedge clk);
      evt_start = 0; cen_valid = 0;
      for (int k = 0; k < n; k++) begin
         cen_valid = 1; cen_val = CWB'(ev_vals[k]);
         evt_end = (overlap && k == n - 1);
         @(negedge clk);
      end
      cen_valid = 0;
      if (!(overlap && n > 0)) begin
         evt_end = 1;
         @(negedge clk);
      end
      evt_end = 0;
      cen_valid = 1; cen_val = 6'd12;                  // after close, R4
      @(negedge clk);
      cen_valid = 0;
   endtask

   task automatic finish_event(input int n, input string tag);
      int hw [0:127];
      int nh = 0, nst;
      bit dropx;
      for (int t = 0; t < 3000 && !blk_done; t++) @(negedge clk);
      @(negedge clk);
      check({tag, " block done"}, {31'b0, blk_done}, 32'd1);
      for (int k = 0; k < n; k++) begin
         for (int i = NR - 1; i >= 0; i--) ;
         begin
            int sel = -1;
            for (int i = 0; i < NR && sel < 0; i++)
               if (m_vld[i] && ev_vals[k] >= m_lo[i] && ev_vals[k] <= m_hi[i]) sel = i;
            if (sel >= 0) begin
               if (nh < 128) hw[nh] = (sel << 24) | ev_vals[k];
               nh++;
            end
         end
      end
      nst   = (nh > DEP) ? DEP : nh;
      dropx = (nh > DEP);
      check({tag, " R5 word count"}, ncap, nst + 2);
      check({tag, " R5/R11 header"}, cap[0], {8'hE1, 8'(exp_evt), 16'(nst)});
      for (int k = 0; k < nst && k + 1 < 256; k++)
         check({tag, " R2/R3 hit word"}, cap[k + 1], hw[k]);
      check({tag, " R5/R8/R9 trailer"}, cap[(nst + 1) % 256],
            {8'hFE, 22'b0, dropx, m_rovf});
      exp_evt = (exp_evt + 1) % 256;
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) begin m_vld[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {29'b0, bus_req, bus_hold, out_wr}, 32'h0);
      rst_n = 1;
      @(negedge clk);
      check("R1 idle outputs", {29'b0, bus_req, bus_hold, out_wr}, 32'h0);

      // R1: empty table after reset
      for (int v = 0; v < 64; v++) ev_vals[v] = v;
      drive_event(64, 1);
      finish_event(64, "R1 empty table");

      // R2 R3 R4: full sweep with overlapping, single-point and empty windows
      load_road(0, 10, 20);
      load_road(1, 15, 30);
      load_road(2, 40, 40);
      load_road(3, 0, 0);
      load_road(4, 63, 63);
      load_road(5, 50, 45);
      drive_event(64, 1);
      finish_event(64, "R2 R3 R4 sweep overlap");
      drive_event(64, 0);
      finish_event(64, "R4 sweep separate end");

      // reverse order pattern, arrival order kept
      for (int v = 0; v < 64; v++) ev_vals[v] = 63 - v;
      drive_event(64, 1);
      finish_event(64, "R5 reverse order");

      // R6: no grant, request held, nothing written
      gnt_allow = 0;
      for (int v = 0; v < 8; v++) ev_vals[v] = 10 + v;
      drive_event(8, 1);
      repeat (10) @(negedge clk);
      check("R6 request while waiting", {31'b0, bus_req}, 32'd1);
      check("R6 no write before grant", ncap, 0);
      gnt_allow = 1;
      finish_event(8, "R6 after grant");

      // R12: grant toggling during readout
      for (int v = 0; v < 40; v++) ev_vals[v] = v;
      drive_event(40, 1);
      stall_mode = 1;
      finish_event(40, "R12 stalled readout");
      stall_mode = 0;
      gnt_allow = 1;

      // R8: store overflow
      clear_roads();
      load_road(0, 0, 63);
      for (int v = 0; v < 70; v++) ev_vals[v] = v % 64;
      drive_event(70, 1);
      finish_event(70, "R8 overflow");

      // R9: out-of-range load ignored, flag set
      load_road(9, 0, 63);
      load_road(1, 5, 5);
      for (int v = 0; v < 64; v++) ev_vals[v] = v;
      drive_event(64, 1);
      finish_event(64, "R9 road overflow");

      // R10: clear invalidates slots and flag
      clear_roads();
      drive_event(64, 1);
      finish_event(64, "R10 after clear");

      // R11: event number wraps
      while (exp_evt != 0) begin
         drive_event(0, 0);
         finish_event(0, "R11 wrap");
      end
      drive_event(0, 0);
      finish_event(0, "R11 after wrap");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule